// File: doc/BRIEF.md
# Multiplexed BCD Display Scanner

This block presents several stored four-bit BCD digits one at a time on a single shared four-bit output. It also drives one active-low select line per digit, so that an external multiplexed display lights only the position whose value is on the shared bus. Each step of the scan happens on a slow scan tick. The tick comes from one of two sources: a programmable prescaler that divides the system clock, or rising edges on an external scan-clock pin that the block synchronizes to its clock. A mode input picks the source.

A functional master reset input parks the scanner. While it is held high, the position is forced to digit one, every select is driven inactive so the display goes dark, and no tick can move the position. When the master reset is released, the display stays dark until the first tick arrives. On that tick digit one lights, and the scan then repeats in order from digit one to the last digit.

The control is a two-state machine. **PARK** is entered from any state when master reset is sampled high or on system reset. In PARK all selects are high and the position is zero. The transition *PARK→SCAN* takes place on the first tick with master reset low, and it lights digit one. In **SCAN**, each tick takes the *SCAN→SCAN advance* transition, which moves to the next digit and wraps from the last digit to digit one. The transition *SCAN→PARK* is taken whenever master reset is sampled high.

Top module: `bcd_scan_top`

## Requirements
- R1: `bcd_out` carries the digit at the current scan position. Digit i is taken from `digits_in[4*i+3:4*i]`, and digit one is i = 0.
- R2: The selects are active low. `dsel_n[0]` selects digit one, the least significant digit, and `dsel_n[NUM_DIGITS-1]` selects the most significant digit. In SCAN exactly one select is low.
- R3: Whenever `dsel_n[i]` is low, `bcd_out` equals digit i in that same cycle. Output value and select change in the same clock cycle.
- R4: From the first clock edge that samples `mreset` high, and for as long as it stays high, `dsel_n` is all ones and `bcd_out` shows digit one.
- R5: While `mreset` is high, no tick takes effect. The prescaler restarts from zero, and external scan-clock edges are ignored.
- R6: In SCAN, each tick moves the position one step: digit 1, 2, …, NUM_DIGITS, then back to 1. Without a tick the position holds.
- R7: After `mreset` is released the selects stay high until the first tick. That tick lights digit one.
- R8: With `ext_mode` = 0, a tick occurs on every (`prescale_lim`+1)-th clock edge after release. After n edges the number of ticks is floor(n/(`prescale_lim`+1)).
- R9: With `ext_mode` = 1, each rising edge of `scan_clk_in` passes through a two-flop synchronizer and produces one tick. If the pin rises before clock edge 1, the outputs change at clock edge 3. Falling edges, steady levels and the prescaler have no effect.
- R10: When `rst_n` is low, the block parks at once, the same as a master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| mreset | input | 1 | Functional master reset, active high; parks and blanks the display |
| ext_mode | input | 1 | Tick source: 0 = internal prescaler, 1 = external scan-clock pin |
| scan_clk_in | input | 1 | External scan clock, asynchronous to `clk` |
| prescale_lim | input | PRE_W | Prescaler limit; tick period is this value + 1 clocks |
| digits_in | input | NUM_DIGITS*DIG_W | Latched BCD digits; digit i occupies bits [DIG_W*i +: DIG_W] |
| bcd_out | output | DIG_W | Shared BCD output, active high |
| dsel_n | output | NUM_DIGITS | Digit select lines, active low |

## Verification
The bench builds the block with three digits, four-bit digits and a three-bit prescaler. This lets it sweep every prescaler limit from 0 to 7 against several digit patterns and predict the select and output values for each cycle using floor division. The small prescaler width also makes the fastest case (a tick every clock) practical. This case exposes the release, wrap and master-reset boundaries. The external-clock path runs with the prescaler set to tick every cycle, so any leak from the prescaler shows up at once. Pulses applied during master reset check that parking wins over pending ticks.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

    typedef enum logic {
        ST_PARK = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

endpackage

// File: rtl/bcd_scan_tick.sv
module bcd_scan_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic             ext_mode,
    input  logic             scan_clk_in,
    input  logic [PRE_W-1:0] prescale_lim,
    output logic             tick
);

    logic [PRE_W-1:0] div_cnt;
    logic             sync_a;
    logic             sync_b;
    logic             sync_prev;
    logic             int_tick;
    logic             ext_tick;

    assign int_tick = (div_cnt >= prescale_lim);
    assign ext_tick = sync_b & ~sync_prev;
    assign tick     = ~mreset & (ext_mode ? ext_tick : int_tick);

    // prescaler: restarts from zero while parked (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (mreset || int_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // two-flop synchronizer plus edge history (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_a    <= scan_clk_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    assert_tick_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |-> !tick);

    assert_ext_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && tick) |=> !tick);

endmodule

// File: rtl/bcd_scan_fsm.sv
module bcd_scan_fsm
    import bcd_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    parameter int POS_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mreset,
    input  logic                  tick,
    output logic [POS_W-1:0]      pos,
    output logic [NUM_DIGITS-1:0] dsel_n,
    output scan_state_t           state
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_DIGITS - 1);

    scan_state_t      state_q;
    scan_state_t      state_d;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_PARK: begin
                pos_d = '0;
                if (!mreset && tick) begin
                    state_d = ST_SCAN;      // PARK->SCAN, digit one (R7)
                end
            end
            ST_SCAN: begin
                if (mreset) begin
                    state_d = ST_PARK;      // SCAN->PARK (R4)
                    pos_d   = '0;
                end else if (tick) begin
                    pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;  // advance (R6)
                end
            end
            default: begin
                state_d = ST_PARK;
                pos_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // output decode: one select per position, all high in PARK
    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_sel
        always_comb begin
            dsel_n[gi] = !((state_q == ST_SCAN) && (pos_q == POS_W'(gi)));
        end
    end

    assign pos   = pos_q;
    assign state = state_q;

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ($countones(~dsel_n) == 1));

    assert_park_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (pos_q == '0 && dsel_n == '1));

    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && tick && !mreset) |=>
            (pos_q == (($past(pos_q) == LAST_POS) ? '0 : $past(pos_q) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mreset) |=> $stable(pos_q));

    assert_first_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && tick) |=> (pos_q == '0));

endmodule

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux #(
    parameter int NUM_DIGITS = 3,
    parameter int DIG_W      = 4,
    parameter int POS_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic [NUM_DIGITS*DIG_W-1:0] digits_in,
    input  logic [POS_W-1:0]            pos,
    output logic [DIG_W-1:0]            bcd_out
);

    always_comb begin
        bcd_out = digits_in[DIG_W-1:0];
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (pos == POS_W'(i)) begin
                bcd_out = digits_in[i*DIG_W +: DIG_W];
            end
        end
    end

endmodule

// File: rtl/bcd_scan_top.sv
module bcd_scan_top
    import bcd_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    parameter int DIG_W      = 4,
    parameter int PRE_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mreset,
    input  logic                        ext_mode,
    input  logic                        scan_clk_in,
    input  logic [PRE_W-1:0]            prescale_lim,
    input  logic [NUM_DIGITS*DIG_W-1:0] digits_in,
    output logic [DIG_W-1:0]            bcd_out,
    output logic [NUM_DIGITS-1:0]       dsel_n
);

    localparam int POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic             tick;
    logic [POS_W-1:0] pos;
    scan_state_t      state;

    bcd_scan_tick #(.PRE_W(PRE_W)) u_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .mreset       (mreset),
        .ext_mode     (ext_mode),
        .scan_clk_in  (scan_clk_in),
        .prescale_lim (prescale_lim),
        .tick         (tick)
    );

    bcd_scan_fsm #(.NUM_DIGITS(NUM_DIGITS), .POS_W(POS_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mreset (mreset),
        .tick   (tick),
        .pos    (pos),
        .dsel_n (dsel_n),
        .state  (state)
    );

    bcd_scan_mux #(.NUM_DIGITS(NUM_DIGITS), .DIG_W(DIG_W), .POS_W(POS_W)) u_mux (
        .digits_in (digits_in),
        .pos       (pos),
        .bcd_out   (bcd_out)
    );

    // value on the bus always belongs to the lit digit
    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_pair
        assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !dsel_n[gi] |-> (bcd_out == digits_in[gi*DIG_W +: DIG_W]));
    end

    assert_scan_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_n != '1) |-> (state == ST_SCAN));

endmodule

// File: tb/bcd_scan_top_test.sv
module bcd_scan_top_test;

    localparam int ND    = 3;
    localparam int DW    = 4;
    localparam int PW    = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mreset = 1'b1;
    logic           ext_mode = 1'b0;
    logic           scan_clk_in = 1'b0;
    logic [PW-1:0]  prescale_lim = '0;
    logic [ND*DW-1:0] digits_in = '0;
    logic [DW-1:0]  bcd_out;
    logic [ND-1:0]  dsel_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bcd_scan_top #(.NUM_DIGITS(ND), .DIG_W(DW), .PRE_W(PW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mreset       (mreset),
        .ext_mode     (ext_mode),
        .scan_clk_in  (scan_clk_in),
        .prescale_lim (prescale_lim),
        .digits_in    (digits_in),
        .bcd_out      (bcd_out),
        .dsel_n       (dsel_n)
    );

    // ticks: 0 = parked, t>0 = lit digit (t-1) mod ND
    task automatic expect_ticks(input int t, input string req);
        logic [ND-1:0] es;
        logic [DW-1:0] eb;
        int p;
        if (t == 0) begin
            es = '1;
            eb = digits_in[DW-1:0];
        end else begin
            p  = (t - 1) % ND;
            es = ~(ND'(1) << p);
            eb = digits_in[p*DW +: DW];
        end
        n_cmp++;
        if (dsel_n !== es || bcd_out !== eb) begin
            n_bad++;
            $display("FAIL %s: dsel_n=%b bcd_out=%h expected dsel_n=%b bcd_out=%h",
                     req, dsel_n, bcd_out, es, eb);
        end
    endtask

    task automatic park_cycles(input int k);
        @(negedge clk) mreset = 1'b1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            expect_ticks(0, "R4 R5 parked");
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        digits_in = {4'd3, 4'd2, 4'd1};
        #5;
        expect_ticks(0, "R10 reset state");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_ticks(0, "R10 after reset");

        // internal prescaler sweep: every limit, several digit patterns
        for (int pat = 0; pat < 3; pat++) begin
            case (pat)
                0: digits_in = {4'd3, 4'd2, 4'd1};
                1: digits_in = {4'd9, 4'd0, 4'd7};
                default: digits_in = {4'd0, 4'd9, 4'd5};
            endcase
            for (int lim = 0; lim < (1 << PW); lim++) begin
                park_cycles(lim + 3);             // R5: prescaler would have ticked
                prescale_lim = PW'(lim);
                @(negedge clk) mreset = 1'b0;
                for (int n = 1; n <= (ND + 2) * (lim + 1) + 1; n++) begin
                    @(negedge clk);
                    // R8 R6 R7 R1 R2 R3
                    expect_ticks(n / (lim + 1), "R8 R6 R7 internal scan");
                end
                @(negedge clk) mreset = 1'b1;      // SCAN->PARK
                @(negedge clk);
                expect_ticks(0, "R4 mid-scan park");
            end
        end

        // external scan clock; prescaler set to tick every cycle
        digits_in    = {4'd8, 4'd4, 4'd6};
        prescale_lim = '0;
        ext_mode     = 1'b1;
        park_cycles(2);
        @(negedge clk) scan_clk_in = 1'b1;        // edges during master reset
        @(negedge clk);
        @(negedge clk) scan_clk_in = 1'b0;
        repeat (3) @(negedge clk);
        expect_ticks(0, "R5 ext edges ignored in reset");
        @(negedge clk) mreset = 1'b0;
        repeat (3) @(negedge clk);
        expect_ticks(0, "R9 prescaler ignored, low level no tick");
        for (int k = 1; k <= 2 * ND + 1; k++) begin
            scan_clk_in = 1'b1;
            @(negedge clk);
            expect_ticks(k - 1, "R9 no change after 1 edge");
            @(negedge clk);
            expect_ticks(k - 1, "R9 no change after 2 edges");
            @(negedge clk);
            expect_ticks(k, "R9 advance on edge 3");
            scan_clk_in = 1'b0;
            repeat (3) @(negedge clk);
            expect_ticks(k, "R9 falling edge no tick");
        end

        // asynchronous system reset in mid scan
        #3 rst_n = 1'b0;
        #1 expect_ticks(0, "R10 async park");
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_ticks(0, "R10 stays parked until edge");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule